// File: doc/BRIEF.md
# Cross-Domain Timer Command Strobe Controller

This block sits between a register bus running on one clock and a timer core running on a second, unrelated clock. Software writes an 8-bit control byte. Each set command bit is a one-shot request. The block carries each request into the timer clock domain and turns it into a single-cycle pulse for the core. It never keeps a copy that software could read back.

Two groups of requests travel over two separate toggle handshakes. Each handshake uses two-flop synchronizers in both directions.

- **Command group:** capture into register A, capture into register B, counter restart, immediate load of the buffered registers, and a load at end of cycle.
- **Disable group:** turn the timer off at end of cycle.

Each group has a ready flag on the bus side. While a group's flag is low, new writes to that group are dropped. Two of the requests do not act at once. The load at end of cycle and the disable at end of cycle stay pending in the timer domain until the end-of-cycle input pulses. Their ready flags stay low until the pending action has been carried out.

Top module: `tmr_cmd_strobe`

## Requirements
- R1: After reset, `cmd_rdy` and `en_rdy` are 1, and `cap_a`, `cap_b`, `cnt_restart`, `load_now`, `load_eoc` and `tmr_off` are 0.
- R2: A write with any of `wr_data[4:0]` set, made while `cmd_rdy` is 1, is accepted, and `cmd_rdy` is 0 from the bus clock edge that takes the write.
- R3: An accepted write produces exactly one single-cycle pulse in the timer domain for each immediate bit that is set. The bits are: bit 4 gives `cap_b`, bit 3 gives `cap_a`, bit 2 gives `cnt_restart`, and bit 1 gives `load_now`.
- R4: Immediate bits set in the same accepted write pulse in the same timer clock cycle.
- R5: A write with command bits set, made while `cmd_rdy` is 0, is dropped and produces no pulse.
- R6: A write with `wr_data[4:0]` all zero (bits 6 and 5 are ignored) leaves `cmd_rdy` at 1 and produces no pulse.
- R7: Bit 0 requests a load at end of cycle. `load_eoc` pulses once, in the timer cycle after the first `cyc_end` sampled after the request has been synchronized, and never before. `cmd_rdy` stays 0 while the request is pending. A `cyc_end` with nothing pending produces no pulse.
- R8: `cmd_rdy` returns to 1 once the accepted command has completed in the timer domain.
- R9: Bit 7, written while `en_rdy` is 1, makes `en_rdy` 0 from the accepting edge. `tmr_off` then pulses once, only after `cyc_end`. `en_rdy` stays 0 until that pulse and returns to 1 after it.
- R10: A write of bit 7 while `en_rdy` is 0 is dropped and produces no further `tmr_off` pulse.
- R11: The two groups are independent. A write holding bit 7 and command bits starts both handshakes, and each group completes on its own terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Bus domain reset, asynchronous, active low |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte written |
| cmd_rdy | output | 1 | Command group ready to accept a write |
| en_rdy | output | 1 | Disable group ready to accept a write |
| tmr_clk | input | 1 | Timer core clock |
| tmr_rst_n | input | 1 | Timer domain reset, asynchronous, active low |
| cyc_end | input | 1 | End-of-cycle event from the timer core |
| cap_a | output | 1 | Capture A pulse |
| cap_b | output | 1 | Capture B pulse |
| cnt_restart | output | 1 | Counter restart pulse |
| load_now | output | 1 | Immediate buffered-register load pulse |
| load_eoc | output | 1 | End-of-cycle buffered-register load pulse |
| tmr_off | output | 1 | End-of-cycle timer disable pulse |

## Verification
The bench writes each immediate bit on its own and then all four together. Single writes show that each bit reaches its own output and no other. The bundled write shows that the pulses share one timer cycle. Back-to-back writes show that a write made while the group is busy is dropped rather than queued. Zero-command writes show that the spare bits start nothing. The deferred requests are checked before and after a `cyc_end`, and a `cyc_end` is also given with nothing pending. A write combining disable and restart shows that the two handshakes stay separate.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  // Control byte bit positions (software decodes these)
  localparam int unsigned CTRL_W      = 8;
  localparam int unsigned BIT_DIS_EOC = 7;
  localparam int unsigned BIT_CAP_B   = 4;
  localparam int unsigned BIT_CAP_A   = 3;
  localparam int unsigned BIT_RESTART = 2;
  localparam int unsigned BIT_LD_NOW  = 1;
  localparam int unsigned BIT_LD_EOC  = 0;

  // Command group occupies the low bits of the byte
  localparam int unsigned CMD_W = BIT_CAP_B + 1;
  localparam logic [CMD_W-1:0] CMD_DEFER = CMD_W'(1) << BIT_LD_EOC;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tcs_rst_sync.sv
module tcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/tcs_bus_chan.sv
// Bus-side half of one toggle handshake: accepts a nonzero bundle while
// idle, holds it stable, and stays busy until the acknowledge toggle returns.
module tcs_bus_chan #(
  parameter int unsigned W           = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_bits,
  input  logic         ack_tgl,
  output logic         req_tgl,
  output logic [W-1:0] payload,
  output logic         rdy
);
  logic         ack_s;
  logic         busy_q, busy_d;
  logic         req_q, req_d;
  logic [W-1:0] pl_q, pl_d;
  logic         accept, done;

  tcs_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_tgl),
    .q     (ack_s)
  );

  always_comb begin
    accept = wr_en & ~busy_q & (|wr_bits);
    done   = busy_q & (ack_s == req_q);
    busy_d = busy_q;
    req_d  = req_q;
    pl_d   = pl_q;
    if (accept) begin
      busy_d = 1'b1;
      req_d  = ~req_q;
      pl_d   = wr_bits;
    end else if (done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      pl_q   <= '0;
    end else begin
      busy_q <= busy_d;
      req_q  <= req_d;
      if (accept) pl_q <= pl_d;
    end
  end

  assign req_tgl = req_q;
  assign payload = pl_q;
  assign rdy     = ~busy_q;
endmodule

// File: rtl/tcs_core_chan.sv
// Timer-side half of one toggle handshake: detects a new request, pulses
// immediate bits at once and holds deferred bits until the end-of-cycle event.
module tcs_core_chan #(
  parameter int unsigned   W           = 5,
  parameter logic [W-1:0]  DEFER_MASK  = '0,
  parameter int unsigned   SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_tgl,
  input  logic [W-1:0] payload,
  input  logic         cyc_end,
  output logic [W-1:0] pulse,
  output logic         ack_tgl
);
  logic         req_s;
  logic         seen_q;
  logic         ack_q;
  logic         new_req;
  logic         defer_new;
  logic         defer_done;
  logic         ack_flip;
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] pulse_q, pulse_d;

  tcs_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_tgl),
    .q     (req_s)
  );

  assign new_req = req_s ^ seen_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (DEFER_MASK[i]) begin : g_defer
      assign pend_d[i]  = (new_req & payload[i]) | (pend_q[i] & ~cyc_end);
      assign pulse_d[i] = pend_q[i] & cyc_end;
    end else begin : g_now
      assign pend_d[i]  = 1'b0;
      assign pulse_d[i] = new_req & payload[i];
    end
  end

  always_comb begin
    defer_new  = new_req & (|(payload & DEFER_MASK));
    defer_done = cyc_end & (|pend_q);
    ack_flip   = (new_req & ~defer_new) | defer_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      ack_q   <= 1'b0;
      pend_q  <= '0;
      pulse_q <= '0;
    end else begin
      if (new_req)  seen_q <= req_s;
      if (ack_flip) ack_q  <= ~ack_q;
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse   = pulse_q;
  assign ack_tgl = ack_q;
endmodule

// File: rtl/tmr_cmd_strobe.sv
module tmr_cmd_strobe
  import tcs_pkg::*;
(
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              cmd_rdy,
  output logic              en_rdy,
  input  logic              tmr_clk,
  input  logic              tmr_rst_n,
  input  logic              cyc_end,
  output logic              cap_a,
  output logic              cap_b,
  output logic              cnt_restart,
  output logic              load_now,
  output logic              load_eoc,
  output logic              tmr_off
);
  logic             b_rst_n, t_rst_n;
  logic             cmd_req, cmd_ack, dis_req, dis_ack;
  logic [CMD_W-1:0] cmd_pl, cmd_pulse;
  logic [0:0]       dis_pl, dis_pulse;
  logic             unused_spare;

  assign unused_spare = ^wr_data[BIT_DIS_EOC-1:CMD_W];

  tcs_rst_sync #(.STAGES(SYNC_DEPTH)) u_bus_rst (
    .clk (bus_clk), .arst_n (bus_rst_n), .rst_n (b_rst_n)
  );
  tcs_rst_sync #(.STAGES(SYNC_DEPTH)) u_tmr_rst (
    .clk (tmr_clk), .arst_n (tmr_rst_n), .rst_n (t_rst_n)
  );

  // Command group
  tcs_bus_chan #(.W(CMD_W), .SYNC_STAGES(SYNC_DEPTH)) u_cmd_bus (
    .clk     (bus_clk),
    .rst_n   (b_rst_n),
    .wr_en   (wr_en),
    .wr_bits (wr_data[CMD_W-1:0]),
    .ack_tgl (cmd_ack),
    .req_tgl (cmd_req),
    .payload (cmd_pl),
    .rdy     (cmd_rdy)
  );
  tcs_core_chan #(.W(CMD_W), .DEFER_MASK(CMD_DEFER), .SYNC_STAGES(SYNC_DEPTH)) u_cmd_core (
    .clk     (tmr_clk),
    .rst_n   (t_rst_n),
    .req_tgl (cmd_req),
    .payload (cmd_pl),
    .cyc_end (cyc_end),
    .pulse   (cmd_pulse),
    .ack_tgl (cmd_ack)
  );

  // Disable group
  tcs_bus_chan #(.W(1), .SYNC_STAGES(SYNC_DEPTH)) u_dis_bus (
    .clk     (bus_clk),
    .rst_n   (b_rst_n),
    .wr_en   (wr_en),
    .wr_bits (wr_data[BIT_DIS_EOC]),
    .ack_tgl (dis_ack),
    .req_tgl (dis_req),
    .payload (dis_pl),
    .rdy     (en_rdy)
  );
  tcs_core_chan #(.W(1), .DEFER_MASK(1'b1), .SYNC_STAGES(SYNC_DEPTH)) u_dis_core (
    .clk     (tmr_clk),
    .rst_n   (t_rst_n),
    .req_tgl (dis_req),
    .payload (dis_pl),
    .cyc_end (cyc_end),
    .pulse   (dis_pulse),
    .ack_tgl (dis_ack)
  );

  assign cap_b       = cmd_pulse[BIT_CAP_B];
  assign cap_a       = cmd_pulse[BIT_CAP_A];
  assign cnt_restart = cmd_pulse[BIT_RESTART];
  assign load_now    = cmd_pulse[BIT_LD_NOW];
  assign load_eoc    = cmd_pulse[BIT_LD_EOC];
  assign tmr_off     = dis_pulse[0];
endmodule

// File: rtl/tcs_strobe_checker.sv
module tcs_strobe_checker (
  input logic       bus_clk,
  input logic       bus_rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       cmd_rdy,
  input logic       en_rdy,
  input logic       tmr_clk,
  input logic       tmr_rst_n,
  input logic       cyc_end,
  input logic       cap_a,
  input logic       cap_b,
  input logic       cnt_restart,
  input logic       load_now,
  input logic       load_eoc,
  input logic       tmr_off
);
  a_r2_rdy_falls: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_en && cmd_rdy && (wr_data[4:0] != 5'd0)) |=> !cmd_rdy);

  a_r6_zero_write: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_en && cmd_rdy && (wr_data[4:0] == 5'd0)) |=> cmd_rdy);

  a_r9_en_rdy_falls: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_en && en_rdy && wr_data[7]) |=> !en_rdy);

  a_r3_cap_a_single: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    cap_a |=> !cap_a);
  a_r3_cap_b_single: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    cap_b |=> !cap_b);
  a_r3_restart_single: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    cnt_restart |=> !cnt_restart);
  a_r3_load_now_single: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    load_now |=> !load_now);

  a_r7_load_after_eoc: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    load_eoc |-> $past(cyc_end));

  a_r9_off_after_eoc: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    tmr_off |-> $past(cyc_end));
endmodule

bind tmr_cmd_strobe tcs_strobe_checker u_chk (
  .bus_clk     (bus_clk),
  .bus_rst_n   (bus_rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .cmd_rdy     (cmd_rdy),
  .en_rdy      (en_rdy),
  .tmr_clk     (tmr_clk),
  .tmr_rst_n   (tmr_rst_n),
  .cyc_end     (cyc_end),
  .cap_a       (cap_a),
  .cap_b       (cap_b),
  .cnt_restart (cnt_restart),
  .load_now    (load_now),
  .load_eoc    (load_eoc),
  .tmr_off     (tmr_off)
);

// File: tb/tmr_cmd_strobe_test.sv
`timescale 1ns/100ps
module tmr_cmd_strobe_test;
  logic       bus_clk, bus_rst_n, wr_en;
  logic [7:0] wr_data;
  logic       cmd_rdy, en_rdy;
  logic       tmr_clk, tmr_rst_n, cyc_end;
  logic       cap_a, cap_b, cnt_restart, load_now, load_eoc, tmr_off;

  int  n_tot, n_bad;
  bit  finished;
  // pulse counters: 0 cap_a, 1 cap_b, 2 restart, 3 load_now, 4 load_eoc, 5 tmr_off
  int  cnt [6];
  int  base[6];
  int  n_tog, n_wide;
  logic [5:0] prev_q;

  tmr_cmd_strobe uut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_rdy(cmd_rdy), .en_rdy(en_rdy), .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
    .cyc_end(cyc_end), .cap_a(cap_a), .cap_b(cap_b), .cnt_restart(cnt_restart),
    .load_now(load_now), .load_eoc(load_eoc), .tmr_off(tmr_off)
  );

  initial bus_clk = 1'b0;
  always #5 bus_clk = ~bus_clk;      // 100 MHz
  initial tmr_clk = 1'b0;
  always #6.5 tmr_clk = ~tmr_clk;    // unrelated timer clock

  // Pulse monitor, sampled away from the timer edge
  always @(negedge tmr_clk) begin
    logic [5:0] now;
    now = {tmr_off, load_eoc, load_now, cnt_restart, cap_b, cap_a};
    if (tmr_rst_n) begin
      for (int i = 0; i < 6; i++) if (now[i]) cnt[i]++;
      if (cap_a && cap_b && cnt_restart && load_now) n_tog++;
      if ((now[3:0] & prev_q[3:0]) != 4'd0) n_wide++;
    end
    prev_q = now;
  end

  task automatic check(input string req, input int act, input int exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic snap();
    for (int i = 0; i < 6; i++) base[i] = cnt[i];
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic bus_wait(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic wait_cmd_rdy();
    for (int i = 0; i < 200 && !cmd_rdy; i++) @(negedge bus_clk);
  endtask

  task automatic wait_en_rdy();
    for (int i = 0; i < 200 && !en_rdy; i++) @(negedge bus_clk);
  endtask

  task automatic pulse_eoc();
    @(negedge tmr_clk); cyc_end = 1'b1;
    @(negedge tmr_clk); cyc_end = 1'b0;
    repeat (3) @(negedge tmr_clk);
  endtask

  task automatic t_reset();
    check("R1 cmd_rdy", cmd_rdy, 1);
    check("R1 en_rdy", en_rdy, 1);
    check("R1 outputs", {cap_a, cap_b, cnt_restart, load_now, load_eoc, tmr_off}, 0);
  endtask

  task automatic t_single();
    // bit 4 cap_b (idx1), bit 3 cap_a (idx0), bit 2 restart (idx2), bit 1 load_now (idx3)
    int bitpos[4] = '{4, 3, 2, 1};
    int idx[4]    = '{1, 0, 2, 3};
    for (int k = 0; k < 4; k++) begin
      snap();
      bus_write(8'(1 << bitpos[k]));
      check("R2 cmd_rdy low after accept", cmd_rdy, 0);
      wait_cmd_rdy();
      bus_wait(4);
      check("R8 cmd_rdy back", cmd_rdy, 1);
      for (int j = 0; j < 6; j++)
        check("R3 pulse count", cnt[j] - base[j], (j == idx[k]) ? 1 : 0);
    end
  endtask

  task automatic t_bundle();
    int tog0;
    tog0 = n_tog;
    snap();
    bus_write(8'h1E);
    wait_cmd_rdy();
    bus_wait(4);
    check("R4 same-cycle pulses", n_tog - tog0, 1);
    for (int j = 0; j < 4; j++) check("R4 bundle count", cnt[j] - base[j], 1);
  endtask

  task automatic t_busy();
    snap();
    bus_write(8'h08);
    bus_write(8'h10);   // cmd_rdy is low here
    wait_cmd_rdy();
    bus_wait(4);
    check("R5 accepted cap_a", cnt[0] - base[0], 1);
    check("R5 dropped cap_b", cnt[1] - base[1], 0);
  endtask

  task automatic t_zero();
    snap();
    bus_write(8'h60);
    check("R6 spare bits keep cmd_rdy", cmd_rdy, 1);
    bus_write(8'h00);
    check("R6 zero keeps cmd_rdy", cmd_rdy, 1);
    bus_wait(30);
    for (int j = 0; j < 6; j++) check("R6 no pulse", cnt[j] - base[j], 0);
  endtask

  task automatic t_eoc_load();
    snap();
    pulse_eoc();
    check("R7 stray cyc_end no load", cnt[4] - base[4], 0);
    bus_write(8'h01);
    bus_wait(30);
    check("R7 no load before cyc_end", cnt[4] - base[4], 0);
    check("R7 cmd_rdy held while pending", cmd_rdy, 0);
    pulse_eoc();
    check("R7 load after cyc_end", cnt[4] - base[4], 1);
    wait_cmd_rdy();
    check("R8 cmd_rdy after deferred load", cmd_rdy, 1);
    pulse_eoc();
    check("R7 single load", cnt[4] - base[4], 1);
  endtask

  task automatic t_disable();
    snap();
    bus_write(8'h80);
    check("R9 en_rdy low after accept", en_rdy, 0);
    bus_write(8'h80);   // dropped: en_rdy low
    bus_wait(30);
    check("R9 no off before cyc_end", cnt[5] - base[5], 0);
    check("R9 en_rdy held", en_rdy, 0);
    pulse_eoc();
    check("R9 off after cyc_end", cnt[5] - base[5], 1);
    wait_en_rdy();
    check("R9 en_rdy back", en_rdy, 1);
    pulse_eoc();
    check("R10 dropped disable", cnt[5] - base[5], 1);
  endtask

  task automatic t_mixed();
    snap();
    bus_write(8'h84);
    check("R11 cmd_rdy low", cmd_rdy, 0);
    check("R11 en_rdy low", en_rdy, 0);
    wait_cmd_rdy();
    bus_wait(4);
    check("R11 restart done", cnt[2] - base[2], 1);
    check("R11 en_rdy still low", en_rdy, 0);
    pulse_eoc();
    wait_en_rdy();
    check("R11 off done", cnt[5] - base[5], 1);
    check("R11 en_rdy back", en_rdy, 1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_tot++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    n_tot = 0; n_bad = 0; finished = 1'b0;
    n_tog = 0; n_wide = 0; prev_q = '0;
    for (int i = 0; i < 6; i++) cnt[i] = 0;
    wr_en = 1'b0; wr_data = 8'h00; cyc_end = 1'b0;
    bus_rst_n = 1'b0; tmr_rst_n = 1'b0;
    bus_wait(5);
    bus_rst_n = 1'b1; tmr_rst_n = 1'b1;
    bus_wait(10);
    t_reset();
    t_single();
    t_bundle();
    t_busy();
    t_zero();
    t_eoc_load();
    t_disable();
    t_mixed();
    check("R3 single-cycle pulses", n_wide, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule